// File: doc/BRIEF.md
# Strobe-Driven Toggle Clock Divider

This block turns one system clock into a slow, even-duty clock without using any divided signal as a clock. A modulo counter raises a one-cycle enable strobe once per counting period. A small two-state machine samples that strobe on the system clock and changes phase each time it finds the strobe high. The strobe and the state machine's phase both leave the block. With the default period of 100 and a 100 MHz input, the phase output is a 500 kHz square wave with 50% duty. Downstream logic can use the phase as a level and the strobe as a clock enable. Both stay in the single clock domain.

The state machine has two states. `PH_LOW` drives the phase output low and `PH_HIGH` drives it high. The transition `PH_LOW -> PH_HIGH` is taken on a system clock edge where the strobe is high, and so is `PH_HIGH -> PH_LOW`. Without a strobe the machine stays in its current state. Synchronous reset forces `PH_LOW` from either state and clears the counter. The counter runs from 0 to `TICK_PERIOD-1`, wraps, and asserts the strobe while it holds its last value.

Top module: `strobe_toggle_div`

## Requirements
- R1: While `rst` is sampled high at a rising edge of `clk_sys`, both `tick_out` and `clk_half` are 0 after that edge.
- R2: Outside reset, `tick_out` is high for exactly one cycle in every `TICK_PERIOD` (default 100) consecutive cycles, and never in two consecutive cycles.
- R3: After reset is released, the first rising edge is cycle 1. `tick_out` is first high after cycle `TICK_PERIOD-1` (cycle 99 by default). It then recurs after every cycle n with n mod `TICK_PERIOD` = `TICK_PERIOD-1`.
- R4: At each rising edge where `tick_out` is high and reset is low, `clk_half` inverts (state `PH_LOW` to `PH_HIGH` or back).
- R5: At a rising edge where `tick_out` is low and reset is low, `clk_half` keeps its value.
- R6: `clk_half` holds each level for exactly `TICK_PERIOD` cycles. After release it is low for cycles 0..99, then high for cycles 100..199, and so on. The result is a 50% duty clock at 1/(2·`TICK_PERIOD`) of the input rate.
- R7: If reset is asserted in the cycle where `tick_out` is high, reset wins. `clk_half` is 0 and `tick_out` is 0 after that edge, and counting restarts so the next strobe again follows R3.
- R8: Reset asserted while `clk_half` is high returns it to 0 at the next edge. After release the R6 pattern starts again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_out | output | 1 | One-cycle enable strobe, once per `TICK_PERIOD` cycles |
| clk_half | output | 1 | Toggled phase output, 50% duty, period 2·`TICK_PERIOD` cycles |

## Verification
Two events can land on the same edge: the strobe that requests a phase change, and a reset that forces `PH_LOW` and clears the counter. The bench provokes this by running up to the strobe cycle and raising reset just before the edge that would toggle the phase. It expects the phase to stay low, the strobe to drop, and the next strobe to come a full period after release. A second collision, reset while the phase is high, is judged the same way. The counter's wrap and the state change also share one edge, so the bench checks the phase at every cycle over several full output periods.

// File: rtl/std_pkg.sv
package std_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    function automatic int cnt_width(input int period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/std_tick_counter.sv
module std_tick_counter #(
    parameter int TICK_PERIOD = 100
) (
    input  logic clk_sys,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = std_pkg::cnt_width(TICK_PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_PERIOD - 1);

    generate
        if (TICK_PERIOD > 1) begin : g_count
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk_sys) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            always_comb begin
                tick = (cnt_q == LAST) && !rst;
            end
        end else begin : g_every
            always_comb begin
                tick = !rst;
            end
        end
    endgenerate

endmodule

// File: rtl/std_phase_fsm.sv
module std_phase_fsm
    import std_pkg::*;
(
    input  logic clk_sys,
    input  logic rst,
    input  logic tick,
    output logic phase
);
    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk_sys) begin
        if (rst) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW: begin
                if (tick) state_d = PH_HIGH;
            end
            PH_HIGH: begin
                if (tick) state_d = PH_LOW;
            end
            default: state_d = PH_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_HIGH: phase = 1'b1;
            default: phase = 1'b0;
        endcase
    end

endmodule

// File: rtl/strobe_toggle_div.sv
module strobe_toggle_div #(
    parameter int TICK_PERIOD = 100
) (
    input  logic clk_sys,
    input  logic rst,
    output logic tick_out,
    output logic clk_half
);
    logic tick_w;

    std_tick_counter #(
        .TICK_PERIOD(TICK_PERIOD)
    ) tick_i (
        .clk_sys(clk_sys),
        .rst    (rst),
        .tick   (tick_w)
    );

    std_phase_fsm phase_i (
        .clk_sys(clk_sys),
        .rst    (rst),
        .tick   (tick_w),
        .phase  (clk_half)
    );

    assign tick_out = tick_w;

endmodule

// File: rtl/strobe_toggle_div_chk.sv
module strobe_toggle_div_chk #(
    parameter int TICK_PERIOD = 100
) (
    input logic clk_sys,
    input logic rst,
    input logic tick_out,
    input logic clk_half
);
    int gap_q;
    int run_q;

    always_ff @(posedge clk_sys) begin
        if (rst || tick_out) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    always_ff @(posedge clk_sys) begin
        if (rst) begin
            run_q <= 0;
        end else if (tick_out) begin
            run_q <= 0;
        end else begin
            run_q <= run_q + 1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_sys)
        rst |=> (!clk_half));

    assert_tick_in_reset_R1: assert property (@(posedge clk_sys)
        rst |-> !tick_out);

    assert_tick_spacing_R2: assert property (@(posedge clk_sys) disable iff (rst)
        tick_out |-> (gap_q == TICK_PERIOD - 1));

    assert_tick_single_R2: assert property (@(posedge clk_sys) disable iff (rst)
        (tick_out && (TICK_PERIOD > 1)) |=> !tick_out);

    assert_no_late_tick_R3: assert property (@(posedge clk_sys) disable iff (rst)
        (gap_q >= TICK_PERIOD - 1) |-> tick_out);

    assert_toggle_on_tick_R4: assert property (@(posedge clk_sys) disable iff (rst)
        tick_out |=> (clk_half != $past(clk_half)));

    assert_hold_no_tick_R5: assert property (@(posedge clk_sys) disable iff (rst)
        !tick_out |=> $stable(clk_half));

    assert_level_length_R6: assert property (@(posedge clk_sys) disable iff (rst)
        tick_out |-> (run_q == TICK_PERIOD - 1));

endmodule

bind strobe_toggle_div strobe_toggle_div_chk #(
    .TICK_PERIOD(TICK_PERIOD)
) chk_i (
    .clk_sys (clk_sys),
    .rst     (rst),
    .tick_out(tick_out),
    .clk_half(clk_half)
);

// File: tb/strobe_toggle_div_tb.sv
module strobe_toggle_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 100;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk_sys = 1'b0;
    logic rst = 1'b1;
    logic tick_out;
    logic clk_half;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    logic done = 1'b0;

    strobe_toggle_div #(.TICK_PERIOD(P)) dut_i (
        .clk_sys (clk_sys),
        .rst     (rst),
        .tick_out(tick_out),
        .clk_half(clk_half)
    );

    always #(CLK_PERIOD/2) clk_sys = ~clk_sys;

    task automatic check(input logic ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp_v);
        end
    endtask

    task automatic step();
        @(negedge clk_sys);
    endtask

    task automatic apply_reset(input int n);
        rst = 1'b1;
        for (int k = 0; k < n; k++) begin
            step();
            check(clk_half == 1'b0, "R1 clk_half", clk_half, 0);
            check(tick_out == 1'b0, "R1 tick_out", tick_out, 0);
        end
        rst = 1'b0;
        cyc = 0;
    endtask

    task automatic run_checked(input int n, input string tag);
        logic prev_clk;
        logic prev_tick;
        int strobes;
        prev_clk = clk_half;
        prev_tick = tick_out;
        strobes = 0;
        for (int k = 0; k < n; k++) begin
            step();
            cyc++;
            check(tick_out == ((cyc % P) == P - 1), {"R3 strobe position ", tag},
                  tick_out, int'((cyc % P) == P - 1));
            check(clk_half == ((cyc / P) % 2), {"R6 level ", tag},
                  clk_half, (cyc / P) % 2);
            if (prev_tick)
                check(clk_half != prev_clk, {"R4 toggle ", tag}, clk_half, !prev_clk);
            else
                check(clk_half == prev_clk, {"R5 hold ", tag}, clk_half, prev_clk);
            if (prev_tick && tick_out)
                check(1'b0, {"R2 back-to-back ", tag}, 1, 0);
            if (tick_out) strobes++;
            if ((cyc % P) == 0) begin
                check(strobes == 1, {"R2 one per window ", tag}, strobes, 1);
                strobes = 0;
            end
            prev_clk = clk_half;
            prev_tick = tick_out;
        end
    endtask

    task automatic t_reset_state();
        apply_reset(4);
    endtask

    task automatic t_steady_run();
        apply_reset(2);
        run_checked(8 * P, "steady");
    endtask

    task automatic t_reset_on_strobe();
        apply_reset(2);
        run_checked(P - 1, "pre-collision");
        check(tick_out == 1'b1, "R7 strobe present", tick_out, 1);
        rst = 1'b1;
        step();
        check(clk_half == 1'b0, "R7 no toggle under reset", clk_half, 0);
        check(tick_out == 1'b0, "R7 strobe dropped", tick_out, 0);
        rst = 1'b0;
        cyc = 0;
        run_checked(3 * P, "after collision R7");
    endtask

    task automatic t_reset_while_high();
        apply_reset(2);
        run_checked(P + P/2, "to high phase");
        check(clk_half == 1'b1, "R8 phase high before reset", clk_half, 1);
        rst = 1'b1;
        step();
        check(clk_half == 1'b0, "R8 phase cleared", clk_half, 0);
        rst = 1'b0;
        cyc = 0;
        run_checked(4 * P, "after R8 reset");
    endtask

    initial begin : wdog
        repeat (WATCHDOG_CYCLES) @(posedge clk_sys);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        step();
        t_reset_state();
        t_steady_run();
        t_reset_on_strobe();
        t_reset_while_high();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule